// File: doc/BRIEF.md
# Tag Load/Store Execution Unit

This unit sits in the execution stage and carries out two tag instructions on double words. A tag read fetches the metadata tag attached to a double word from the tagged data cache and returns it zero-extended to a destination register. A tag write takes the low tag bits of a source register and writes them as the tag of a double word. The data bits of that double word are left alone. Neither instruction carries data, so every cache access the unit makes is a tag-only access to one double word.

The effective address is the base register plus the 12-bit immediate, with the immediate sign-extended first. When the low three address bits are not zero, the instruction is refused. The unit raises an exception and reports the faulting address in the same cycle it takes the instruction, and it never contacts the cache for it. An aligned instruction is held as a single in-flight request until the cache responds.

The issue port and the cache request port use valid/ready. An issue transfer happens only when `in_valid` and `in_ready` are both high, and `in_ready` is low for as long as a request is in flight. On the cache request port, the unit holds `req_valid` and the request fields unchanged until `req_ready` is sampled high. The cache response and the register writeback are single-cycle pulses and cannot be back-pressured.

Top module: `tagops_unit`

## Requirements
- R1: The cache request address equals `in_base` plus the sign-extended 12-bit `in_imm`, taken modulo 2^64.
- R2: An issue transfer whose effective address has any of bits [2:0] set raises `exc_valid` in that same cycle, with `exc_addr` equal to the effective address. No cache request follows, and the unit stays idle.
- R3: An aligned issue transfer raises `req_valid` in the next cycle. `req_write` is 0 for a tag read (`in_op`=0) and 1 for a tag write (`in_op`=1). `req_valid`, `req_addr` and `req_write` stay stable until `req_ready` is sampled high, and `req_valid` is low in the cycle after that handshake.
- R4: For a tag write, `req_tag` equals the low TAG_W (default 4) bits of `in_src`. The higher bits of `in_src` have no effect.
- R5: For a tag read, the cycle after `rsp_valid` is sampled while waiting for the response, `wb_valid` is high for exactly one cycle. In that cycle `wb_data` is `rsp_tag` zero-extended to 64 bits and `wb_rd` is the issued `in_rd`.
- R6: `busy` is high from the cycle after an aligned issue transfer until the cycle after the response. `in_ready` is the inverse of `busy`, and `in_valid` has no effect while busy: no exception is raised and no extra request is made.
- R7: A `rsp_valid` pulse while the request has not yet been accepted is ignored. The request stays pending and no writeback occurs.
- R8: Completion of a tag write produces no `wb_valid` pulse.
- R9: After reset the unit is idle: `busy`, `req_valid`, `wb_valid` and `exc_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can take an instruction |
| in_op | input | 1 | 0 = tag read, 1 = tag write |
| in_base | input | 64 | Base register value |
| in_imm | input | 12 | Signed address offset |
| in_src | input | 64 | Source register holding the tag to write |
| in_rd | input | 5 | Destination register index |
| exc_valid | output | 1 | Misalignment exception pulse |
| exc_addr | output | 64 | Faulting effective address |
| req_valid | output | 1 | Tag-only cache request valid |
| req_ready | input | 1 | Cache accepts the request |
| req_write | output | 1 | 1 = write tag, 0 = read tag |
| req_addr | output | 64 | Double-word address |
| req_tag | output | 4 | Tag to write |
| rsp_valid | input | 1 | Cache response pulse |
| rsp_tag | input | 4 | Tag read from the cache |
| wb_valid | output | 1 | Destination register write pulse |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 64 | Zero-extended tag |
| busy | output | 1 | A request is in flight |

## Verification
A state register stuck in or skipping the request phase shows within one cycle: `req_valid` is missing after an aligned issue, or stays high after the handshake. A corrupt latched address or tag appears on `req_addr` or `req_tag` in the first request cycle. A wrong latched destination or operation appears on the writeback pulse one cycle after the response. A broken alignment decode shows in the issue cycle itself, either as a missing exception or as a request after a misaligned address.

// File: rtl/tagops_pkg.sv
package tagops_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } tagops_state_t;

  localparam logic OP_READ  = 1'b0;
  localparam logic OP_WRITE = 1'b1;
endpackage

// File: rtl/tagops_agen.sv
module tagops_agen #(
  parameter int XLEN     = 64,
  parameter int IMM_W    = 12,
  parameter int DW_BYTES = 8
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  ea,
  output logic             misaligned
);
  localparam int OFS_W = $clog2(DW_BYTES);

  logic [XLEN-1:0] imm_sx;
  assign imm_sx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign ea     = base + imm_sx;

  generate
    if (OFS_W > 0) begin : g_chk
      assign misaligned = |ea[OFS_W-1:0];
    end else begin : g_nochk
      assign misaligned = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tagops_fmt.sv
module tagops_fmt #(
  parameter int XLEN  = 64,
  parameter int TAG_W = 4
) (
  input  logic [XLEN-1:0]  src,
  input  logic [TAG_W-1:0] tag_in,
  output logic [TAG_W-1:0] tag_out,
  output logic [XLEN-1:0]  wide_out
);
  assign tag_out = src[TAG_W-1:0];

  generate
    if (TAG_W < XLEN) begin : g_pad
      assign wide_out = {{(XLEN-TAG_W){1'b0}}, tag_in};
    end else begin : g_full
      assign wide_out = tag_in[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/tagops_fsm.sv
module tagops_fsm
  import tagops_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          req_ready,
  input  logic          rsp_valid,
  output tagops_state_t state,
  output logic          done
);
  tagops_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (accept)    nxt = ST_REQ;
      ST_REQ:  if (req_ready) nxt = ST_WAIT;
      ST_WAIT: if (rsp_valid) nxt = ST_IDLE;
      default:                nxt = ST_IDLE;
    endcase
  end

  assign done = (state == ST_WAIT) && rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/tagops_unit.sv
module tagops_unit
  import tagops_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int IMM_W    = 12,
  parameter int TAG_W    = 4,
  parameter int RD_W     = 5,
  parameter int DW_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_op,
  input  logic [XLEN-1:0]  in_base,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [XLEN-1:0]  in_src,
  input  logic [RD_W-1:0]  in_rd,
  output logic             exc_valid,
  output logic [XLEN-1:0]  exc_addr,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [XLEN-1:0]  req_addr,
  output logic [TAG_W-1:0] req_tag,
  input  logic             rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  output logic             wb_valid,
  output logic [RD_W-1:0]  wb_rd,
  output logic [XLEN-1:0]  wb_data,
  output logic             busy
);
  logic [XLEN-1:0]  ea;
  logic             misaligned;
  logic [TAG_W-1:0] src_tag;
  logic [XLEN-1:0]  rsp_wide;
  logic             fire, accept, done;
  tagops_state_t    state;

  logic [XLEN-1:0]  r_addr;
  logic             r_write;
  logic [TAG_W-1:0] r_tag;
  logic [RD_W-1:0]  r_rd;

  tagops_agen #(.XLEN(XLEN), .IMM_W(IMM_W), .DW_BYTES(DW_BYTES)) u_agen (
    .base(in_base), .imm(in_imm), .ea(ea), .misaligned(misaligned)
  );

  tagops_fmt #(.XLEN(XLEN), .TAG_W(TAG_W)) u_fmt (
    .src(in_src), .tag_in(rsp_tag), .tag_out(src_tag), .wide_out(rsp_wide)
  );

  tagops_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .state(state), .done(done)
  );

  assign in_ready  = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign fire      = in_valid && in_ready;
  assign accept    = fire && !misaligned;
  assign exc_valid = fire && misaligned;
  assign exc_addr  = ea;

  assign req_valid = (state == ST_REQ);
  assign req_write = r_write;
  assign req_addr  = r_addr;
  assign req_tag   = r_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_addr  <= '0;
      r_write <= OP_READ;
      r_tag   <= '0;
      r_rd    <= '0;
    end else if (accept) begin
      r_addr  <= ea;
      r_write <= in_op;
      r_tag   <= src_tag;
      r_rd    <= in_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_rd    <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= done && (r_write == OP_READ);
      if (done) begin
        wb_rd   <= r_rd;
        wb_data <= rsp_wide;
      end
    end
  end
endmodule

// File: rtl/tagops_unit_chk.sv
module tagops_unit_chk #(
  parameter int XLEN  = 64,
  parameter int TAG_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            exc_valid,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [XLEN-1:0] req_addr,
  input logic            wb_valid,
  input logic            busy
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write));

  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  p_exc_noreq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !req_valid && !busy);

  p_exc_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> in_valid && in_ready);

  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !exc_valid |=> busy && req_valid);

  p_busy_noexc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !exc_valid);

  p_wb_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  p_wb_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !busy && !req_valid);
endmodule

bind tagops_unit tagops_unit_chk #(.XLEN(XLEN), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .exc_valid(exc_valid), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .wb_valid(wb_valid), .busy(busy)
);

// File: tb/tagops_unit_tb.sv
module tagops_unit_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_op = 1'b0;
  logic [63:0] in_base = '0, in_src = '0;
  logic [11:0] in_imm = '0;
  logic [4:0]  in_rd = '0;
  logic        req_ready = 1'b0, rsp_valid = 1'b0;
  logic [3:0]  rsp_tag = '0;
  logic        in_ready, exc_valid, req_valid, req_write, wb_valid, busy;
  logic [63:0] exc_addr, req_addr, wb_data;
  logic [3:0]  req_tag;
  logic [4:0]  wb_rd;

  int total = 0, bad = 0;
  logic [3:0] tmem [16];

  always #(CLK_P/2) clk = ~clk;

  tagops_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_base(in_base), .in_imm(in_imm), .in_src(in_src),
    .in_rd(in_rd), .exc_valid(exc_valid), .exc_addr(exc_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_tag(req_tag), .rsp_valid(rsp_valid),
    .rsp_tag(rsp_tag), .wb_valid(wb_valid), .wb_rd(wb_rd),
    .wb_data(wb_data), .busy(busy)
  );

  task automatic chk(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_op(input logic op, input logic [63:0] base, input logic [11:0] imm,
                        input logic [63:0] src, input logic [4:0] rd,
                        input int rdly, input int sdly, input logic spur);
    logic [63:0] ea;
    logic [3:0]  idx, exp_tag;
    ea  = base + {{52{imm[11]}}, imm};
    idx = ea[6:3];
    in_valid = 1'b1; in_op = op; in_base = base; in_imm = imm; in_src = src; in_rd = rd;
    #1;
    chk(in_ready == 1'b1, "R6 ready idle", 64'(in_ready), 64'd1);
    if (ea[2:0] != 3'd0) begin
      chk(exc_valid == 1'b1, "R2 exc raised", 64'(exc_valid), 64'd1);
      chk(exc_addr == ea, "R2 exc addr", exc_addr, ea);
      step();
      in_valid = 1'b0;
      chk(!req_valid && !busy, "R2 no request", {62'd0, req_valid, busy}, 64'd0);
      return;
    end
    chk(exc_valid == 1'b0, "R2 no exc aligned", 64'(exc_valid), 64'd0);
    step();
    // offered while busy: misaligned and must be ignored
    in_base = 64'h3; in_imm = 12'h0; in_op = ~op;
    chk(req_valid && busy, "R3 req raised", {62'd0, req_valid, busy}, 64'd3);
    chk(req_addr == ea, "R1 req addr", req_addr, ea);
    chk(req_write == op, "R3 req op", 64'(req_write), 64'(op));
    if (op) chk(req_tag == src[3:0], "R4 req tag", 64'(req_tag), 64'(src[3:0]));
    for (int k = 0; k < rdly; k++) begin
      if (spur && k == 0) begin rsp_valid = 1'b1; rsp_tag = ~tmem[idx]; end
      step();
      rsp_valid = 1'b0;
      chk(req_valid && req_addr == ea && req_write == op, "R3 hold", req_addr, ea);
      chk(!in_ready && !exc_valid, "R6 busy ignores issue", {62'd0, in_ready, exc_valid}, 64'd0);
      if (spur && k == 0) chk(!wb_valid, "R7 early rsp ignored", 64'(wb_valid), 64'd0);
    end
    req_ready = 1'b1;
    step();
    req_ready = 1'b0;
    if (op) tmem[idx] = src[3:0];
    chk(!req_valid && busy, "R3 req dropped", {62'd0, req_valid, busy}, 64'd1);
    for (int k = 0; k < sdly; k++) begin
      step();
      chk(busy && !wb_valid && !exc_valid, "R6 waiting", {62'd0, busy, wb_valid}, 64'd2);
    end
    exp_tag = tmem[idx];
    rsp_valid = 1'b1; rsp_tag = op ? 4'hF : exp_tag;
    in_valid = 1'b0;
    step();
    rsp_valid = 1'b0;
    chk(!busy && in_ready, "R6 idle after rsp", 64'(busy), 64'd0);
    if (op) begin
      chk(!wb_valid, "R8 no wb on write", 64'(wb_valid), 64'd0);
    end else begin
      chk(wb_valid, "R5 wb pulse", 64'(wb_valid), 64'd1);
      chk(wb_data == {60'd0, exp_tag}, "R5 wb data", wb_data, {60'd0, exp_tag});
      chk(wb_rd == rd, "R5 wb rd", 64'(wb_rd), 64'(rd));
    end
    step();
    chk(!wb_valid && !req_valid, "R5 wb one cycle", 64'(wb_valid), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) tmem[i] = 4'(i ^ 5);
    #(CLK_P*2 + 1);
    chk(!busy && !req_valid && !wb_valid && !exc_valid && in_ready, "R9 reset",
        {59'd0, busy, req_valid, wb_valid, exc_valid, in_ready}, 64'd1);
    @(negedge clk); rst_n = 1'b1; step();
    // sign-extension boundaries
    run_op(1'b1, 64'd0, 12'hFF8, 64'hFFFF_FFFF_FFFF_FFF7, 5'd1, 0, 0, 1'b0);
    run_op(1'b0, 64'd0, 12'hFF8, 64'd0, 5'd2, 1, 1, 1'b0);
    run_op(1'b0, 64'd8, 12'h800, 64'd0, 5'd3, 2, 0, 1'b1);
    run_op(1'b0, 64'h7FF, 12'h7FF, 64'd0, 5'd4, 0, 2, 1'b0);
    run_op(1'b1, 64'hFFFF_FFFF_FFFF_FFF8, 12'h010, 64'hA0, 5'd5, 1, 0, 1'b0);
    run_op(1'b0, 64'hFFFF_FFFF_FFFF_FFF8, 12'h010, 64'd0, 5'd6, 0, 0, 1'b0);
    // sweep every immediate value
    for (int i = 0; i < 4096; i++) begin
      run_op(1'(i % 2), 64'h1000_0000 + 64'(i * 24) + 64'(i % 3 == 0 ? 1 : 0),
             12'(i), 64'hA5A5_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_0101_0117),
             5'(i % 32), i % 3, (i / 3) % 3, (i % 5) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule